// File: doc/BRIEF.md
# Branch fold decision unit

This decode-stage block looks at one fetched 32-bit instruction word per cycle together with a direction bit (taken or predicted taken) and a flag saying whether that direction is already resolved. It sorts the word into one of five classes: unconditional branch, conditional branch, conditional branch through the count register, conditional branch through the link register, or not a branch.

For a branch, it then decides between three outcomes:

- **Fold:** the branch is removed from the pipeline, uses no dispatch slot, and fetch is redirected.
- **Fall through:** fetch simply continues.
- **Dispatch:** the branch must be sent down the pipe because it writes the count or link register. Such a branch is never folded.

Every result is registered, so the outcome for a word presented in one cycle shows up on the outputs in the next cycle. Target address arithmetic and prediction state are handled elsewhere.

Top module: `branch_fold_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises with no valid input, all outputs are 0.
- R2: The class code on `br_class` is derived from the primary opcode (word bits [31:26]) and the extended opcode (word bits [10:1]), as follows:
  - 0: not a branch;
  - 1: primary opcode 18;
  - 2: primary opcode 16;
  - 3: primary opcode 19 with extended opcode 528;
  - 4: primary opcode 19 with extended opcode 16.
  - Primary opcode 19 with any other extended opcode is class 0.
- R3: A taken branch that writes neither the count nor the link register pulses `fold` and does not assert `need_dispatch`.
- R4: A branch whose direction bit is 0 pulses `fall_thru` and never `fold`.
- R5: When the link bit (word bit 0) is 1, the branch writes the link register. It then asserts `need_dispatch`, and `fold` stays 0.
- R6: Classes 2 and 4 decrement the count register when word bit 23 is 0. Such a branch asserts `need_dispatch` and never folds. Classes 1 and 3 never decrement.
- R7: `redirect` is 1 for every taken branch, whether it is folded or dispatched. It is 0 for a branch that is not taken.
- R8: `spec_redirect` is 1 exactly when `redirect` is 1 and the resolved input was 0.
- R9: A cycle with `in_valid` low, or with a non-branch word, drives all strobes to 0 in the following cycle.
- R10: Every output reflects the inputs sampled at the previous rising clock edge: the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Fetched instruction word |
| dir_taken | input | 1 | Branch taken or predicted taken |
| dir_resolved | input | 1 | Direction is resolved, not predicted |
| br_class | output | 3 | Class code (see R2) |
| fold | output | 1 | Branch folded out of the pipeline |
| fall_thru | output | 1 | Branch falls through |
| redirect | output | 1 | Fetch redirect request |
| spec_redirect | output | 1 | Redirect is based on a prediction |
| need_dispatch | output | 1 | Branch must occupy a dispatch slot |

## Verification
Every result of this block is due exactly one rising edge after its word is presented.

The bench drives each word on a falling edge and lets the next rising edge capture it. On the falling edge after that, it compares all six outputs with values computed by a bench function, and only then drives the next word. Idle cycles and non-branch words are mixed into the stream, so each check also confirms that a strobe does not linger from the previous word.

// File: rtl/branch_fold_unit.sv
module branch_fold_unit #(
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] instr,
  input  logic          dir_taken,
  input  logic          dir_resolved,
  output logic [2:0]    br_class,
  output logic          fold,
  output logic          fall_thru,
  output logic          redirect,
  output logic          spec_redirect,
  output logic          need_dispatch
);
  localparam logic [5:0] OP_B   = 6'd18;
  localparam logic [5:0] OP_BC  = 6'd16;
  localparam logic [5:0] OP_X19 = 6'd19;
  localparam logic [9:0] XO_CTR = 10'd528;
  localparam logic [9:0] XO_LR  = 10'd16;

  logic [5:0] prim;
  logic [9:0] xop;
  logic       is_b, is_bc, is_bctr, is_blr, is_br;
  logic       link_wr, ctr_dec, writes_reg;
  logic [2:0] cls_d;

  assign prim    = instr[IW-1 -: 6];
  assign xop     = instr[10:1];
  assign is_b    = prim == OP_B;
  assign is_bc   = prim == OP_BC;
  assign is_bctr = prim == OP_X19 && xop == XO_CTR;
  assign is_blr  = prim == OP_X19 && xop == XO_LR;
  assign is_br   = in_valid && (is_b || is_bc || is_bctr || is_blr);

  assign link_wr    = instr[0];
  assign ctr_dec    = (is_bc || is_blr) && !instr[23];
  assign writes_reg = link_wr || ctr_dec;

  always_comb begin
    cls_d = 3'd0;
    if (in_valid) begin
      if (is_b)         cls_d = 3'd1;
      else if (is_bc)   cls_d = 3'd2;
      else if (is_bctr) cls_d = 3'd3;
      else if (is_blr)  cls_d = 3'd4;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      br_class      <= 3'd0;
      fold          <= 1'b0;
      fall_thru     <= 1'b0;
      redirect      <= 1'b0;
      spec_redirect <= 1'b0;
      need_dispatch <= 1'b0;
    end else begin
      br_class      <= cls_d;
      fold          <= is_br && dir_taken && !writes_reg;
      fall_thru     <= is_br && !dir_taken;
      redirect      <= is_br && dir_taken;
      spec_redirect <= is_br && dir_taken && !dir_resolved;
      need_dispatch <= is_br && writes_reg;
    end
  end

  // R3
  fold_xor_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fold && need_dispatch));
  // R4
  fold_vs_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fold, fall_thru}));
  // R7
  fold_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold |-> redirect);
  // R8
  spec_implies_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spec_redirect |-> redirect);
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (br_class == 3'd0) |-> !(fold || fall_thru || redirect || need_dispatch));
  // R5
  link_no_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && instr[0]) |=> !fold);
endmodule

// File: tb/test_branch_fold_unit.sv
module test_branch_fold_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, dir_taken = 1'b0, dir_resolved = 1'b0;
  logic [31:0] instr = '0;
  logic [2:0] br_class;
  logic fold, fall_thru, redirect, spec_redirect, need_dispatch;
  int vecs = 0, errs = 0;

  always #4 clk = ~clk;

  branch_fold_unit i_branch_fold_unit (
    .clk, .rst_n, .in_valid, .instr, .dir_taken, .dir_resolved,
    .br_class, .fold, .fall_thru, .redirect, .spec_redirect, .need_dispatch);

  function automatic logic [7:0] model(input logic v, input logic [31:0] w,
                                       input logic t, input logic r);
    logic [2:0] c;
    logic br, wr;
    c = 3'd0;
    if (v) begin
      if (w[31:26] == 6'd18) c = 3'd1;
      else if (w[31:26] == 6'd16) c = 3'd2;
      else if (w[31:26] == 6'd19 && w[10:1] == 10'd528) c = 3'd3;
      else if (w[31:26] == 6'd19 && w[10:1] == 10'd16) c = 3'd4;
    end
    br = c != 3'd0;
    wr = w[0] || ((c == 3'd2 || c == 3'd4) && !w[23]);
    return {c, br && t && !wr, br && !t, br && t, br && t && !r, br && wr};
  endfunction

  task automatic apply(input logic v, input logic [31:0] w, input logic t,
                       input logic r, input string req);
    logic [7:0] exp;
    @(negedge clk);
    in_valid = v; instr = w; dir_taken = t; dir_resolved = r;
    exp = model(v, w, t, r);
    @(negedge clk);
    vecs++;
    if ({br_class, fold, fall_thru, redirect, spec_redirect, need_dispatch} !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b (instr %h t%b r%b)", req,
               {br_class, fold, fall_thru, redirect, spec_redirect, need_dispatch},
               exp, w, t, r);
    end
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [9:0] xo,
                                     input logic bo2, input logic lk);
    logic [31:0] w;
    w = $urandom;
    w[31:26] = op; w[10:1] = xo; w[23] = bo2; w[0] = lk;
    return w;
  endfunction

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    vecs++;
    if ({br_class, fold, fall_thru, redirect, spec_redirect, need_dispatch} !== 8'd0) begin
      errs++; $display("FAIL R1: got nonzero expected 0");
    end
    rst_n = 1'b1;
    @(negedge clk);
    vecs++;
    if ({br_class, fold, fall_thru, redirect, spec_redirect, need_dispatch} !== 8'd0) begin
      errs++; $display("FAIL R1: got nonzero after reset expected 0");
    end
    apply(1, mk(6'd18, 10'd0, 1, 0), 1, 1, "R3 uncond fold");
    apply(1, mk(6'd18, 10'd0, 0, 1), 1, 0, "R5 uncond link");
    apply(1, mk(6'd16, 10'd0, 1, 0), 1, 0, "R8 cond spec fold");
    apply(1, mk(6'd16, 10'd0, 0, 0), 1, 1, "R6 cond decrement");
    apply(1, mk(6'd16, 10'd0, 1, 0), 0, 1, "R4 cond fall");
    apply(1, mk(6'd19, 10'd528, 0, 0), 1, 1, "R6 ctr no decrement");
    apply(1, mk(6'd19, 10'd16, 0, 0), 1, 1, "R6 lr decrement");
    apply(1, mk(6'd19, 10'd16, 1, 0), 1, 0, "R7 lr fold");
    apply(1, mk(6'd19, 10'd17, 1, 0), 1, 0, "R2 op19 other xo");
    apply(0, mk(6'd18, 10'd0, 1, 0), 1, 0, "R9 invalid");
    apply(1, mk(6'd31, 10'd528, 1, 0), 1, 0, "R9 non-branch");
    apply(1, mk(6'd19, 10'd528, 1, 1), 0, 0, "R4 ctr link fall");
    for (int k = 0; k < 2000; k++) begin
      logic [5:0] op;
      logic [9:0] xo;
      case ($urandom % 6)
        0: op = 6'd18; 1: op = 6'd16; 2, 3: op = 6'd19;
        default: op = 6'($urandom);
      endcase
      case ($urandom % 3)
        0: xo = 10'd528; 1: xo = 10'd16; default: xo = 10'($urandom);
      endcase
      apply(($urandom % 8) != 0, mk(op, xo, 1'($urandom), 1'($urandom)),
            1'($urandom), 1'($urandom), "R10 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule